// File: doc/BRIEF.md
# Double-Buffered Period-Timer PWM Generator

This block produces a pulse-width-modulated waveform. An 8-bit timer with a selectable prescaler sets the period, and a 10-bit duty value sets the high time. Every timer step is split into four equal quarters by a 2-bit fine count. The duty value is therefore compared against the timer joined to that fine count. This gives up to two extra bits of resolution below the timer step.

Software-style write strobes load the period register and a buffered duty value. The duty value is an 8-bit coarse byte plus a 2-bit fine field, and it may be rewritten at any moment. The buffered value moves into the active duty latch only when the timer wraps at the end of a period, so a period already in progress is never disturbed. Each wrap also drives the output high (unless the new duty is zero) and raises a one-clock period pulse.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset `pwm_out` and `period_tick` are low, and the period register holds 0xFF. With that default and prescale 1, ticks are 1024 clocks apart.
- R2: The prescale select is coded as 0 = divide by 1, 1 = divide by 4, 2 or 3 = divide by 16. The distance between two `period_tick` pulses is (period + 1) × 4 × prescale clocks.
- R3: `period_tick` is high for exactly one clock at each timer wrap.
- R4: With an active duty D = {duty_hi, duty_lo} that is nonzero, `pwm_out` goes high in the same cycle as `period_tick` and stays high for exactly D × prescale clocks.
- R5: With an active duty of zero, `pwm_out` stays low for the whole period, including the wrap cycle.
- R6: With an active duty of at least 4 × (period + 1), `pwm_out` is never cleared and stays high for the whole period.
- R7: A duty write is held in a buffer and takes effect only at the next wrap. The period running at the time of the write keeps its old high time.
- R8: When `enable` is low, `pwm_out` is low from the next clock on and the counters are held at zero. After `enable` rises, the output stays low until the first tick, which comes (period + 1) × 4 × prescale clocks later.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the timer; when low, forces the output low |
| presc_sel | input | 2 | Prescale select (0:/1, 1:/4, 2-3:/16) |
| period_wr | input | 1 | Write strobe for the period register |
| period_val | input | 8 | New period value |
| duty_wr | input | 1 | Write strobe for the buffered duty value |
| duty_hi | input | 8 | Upper 8 bits of the duty value |
| duty_lo | input | 2 | Lower 2 bits of the duty value |
| pwm_out | output | 1 | PWM waveform |
| period_tick | output | 1 | One-clock pulse at each timer wrap |

## Verification
Writes land on the clock edge after the strobe. A new duty value first shows in the period that starts at the next tick. The output and the tick are both registered, so the tick and the rising edge of the output appear together in the first clock after the wrap edge. The falling edge of the output comes exactly D × prescale clocks after that first clock. The bench samples on falling edges. It counts clocks from one tick to the next and counts the high clocks in between, then compares both counts with lengths computed from the period, prescale and duty values. After `enable` rises, it counts clocks up to the first tick; after `enable` falls, it checks the output one clock later.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int TMR_W  = 8;
  localparam int FINE_W = 2;
  localparam int DUTY_W = TMR_W + FINE_W;
  localparam int SUB_W  = 6;

  typedef struct packed {
    logic rollover;
    logic hold;
  } ctrlStrb_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int FW = FINE_W,
  parameter int SW = SUB_W,
  parameter logic [TW-1:0] PERIOD_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    presc_sel,
  input  logic          period_wr,
  input  logic [TW-1:0] period_val,
  output ctrlStrb_t     strb,
  output logic [TW+FW-1:0] cmpVal
);
  logic [TW-1:0] tmr, tmrN, periodReg;
  logic [SW-1:0] sub, subN, lastSub;
  logic [FW-1:0] fineN;
  logic stepEnd, rollover;

  always_comb begin
    case (presc_sel)
      2'd0:    lastSub = SW'(3);
      2'd1:    lastSub = SW'(15);
      default: lastSub = SW'(63);
    endcase
  end

  assign stepEnd  = (sub >= lastSub);
  assign rollover = enable && stepEnd && (tmr == periodReg);

  always_comb begin
    if (!enable) begin
      tmrN = '0;
      subN = '0;
    end else begin
      subN = stepEnd ? '0 : sub + 1'b1;
      if (rollover)     tmrN = '0;
      else if (stepEnd) tmrN = tmr + 1'b1;
      else              tmrN = tmr;
    end
  end

  always_comb begin
    case (presc_sel)
      2'd0:    fineN = subN[1:0];
      2'd1:    fineN = subN[3:2];
      default: fineN = subN[5:4];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr       <= '0;
      sub       <= '0;
      periodReg <= PERIOD_RST;
    end else begin
      tmr <= tmrN;
      sub <= subN;
      if (period_wr) periodReg <= period_val;
    end
  end

  assign strb.rollover = rollover;
  assign strb.hold     = !enable;
  assign cmpVal        = {tmrN, fineN};

  // R2
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (tmr == '0 && sub == '0));

  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tmr == '0 && sub == '0));
endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int FW = FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrb_t        strb,
  input  logic [TW+FW-1:0] cmpVal,
  input  logic             duty_wr,
  input  logic [TW-1:0]    duty_hi,
  input  logic [FW-1:0]    duty_lo,
  output logic             pwm_out,
  output logic             period_tick
);
  localparam int DW = TW + FW;
  logic [DW-1:0] dutyBuf, dutyAct;
  logic outQ, tickQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dutyBuf <= '0;
      dutyAct <= '0;
      outQ    <= 1'b0;
      tickQ   <= 1'b0;
    end else begin
      if (duty_wr) dutyBuf <= {duty_hi, duty_lo};
      tickQ <= strb.rollover;
      if (strb.hold) begin
        outQ <= 1'b0;
      end else if (strb.rollover) begin
        dutyAct <= dutyBuf;
        outQ    <= (dutyBuf != '0);
      end else if (cmpVal == dutyAct) begin
        outQ <= 1'b0;
      end
    end
  end

  assign pwm_out     = outQ;
  assign period_tick = tickQ;

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickQ |=> !tickQ);

  // R5
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickQ && dutyAct == '0) |-> !outQ);

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rollover |=> $stable(dutyAct));

  // R8
  disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hold |=> !outQ);

  // R4
  wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickQ && dutyAct != '0) |-> outQ);
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int FW = FINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    presc_sel,
  input  logic          period_wr,
  input  logic [TW-1:0] period_val,
  input  logic          duty_wr,
  input  logic [TW-1:0] duty_hi,
  input  logic [FW-1:0] duty_lo,
  output logic          pwm_out,
  output logic          period_tick
);
  ctrlStrb_t strb;
  logic [TW+FW-1:0] cmpVal;

  pwm_ctrl #(.TW(TW), .FW(FW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
    .period_wr(period_wr), .period_val(period_val),
    .strb(strb), .cmpVal(cmpVal)
  );

  pwm_dp #(.TW(TW), .FW(FW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmpVal(cmpVal),
    .duty_wr(duty_wr), .duty_hi(duty_hi), .duty_lo(duty_lo),
    .pwm_out(pwm_out), .period_tick(period_tick)
  );
endmodule

// File: tb/pwm_dbuf_tb.sv
module pwm_dbuf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic period_wr = 1'b0;
  logic [7:0] period_val = '0;
  logic duty_wr = 1'b0;
  logic [7:0] duty_hi = '0;
  logic [1:0] duty_lo = '0;
  logic pwm_out, period_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
    .period_wr(period_wr), .period_val(period_val), .duty_wr(duty_wr),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .pwm_out(pwm_out),
    .period_tick(period_tick)
  );

  function automatic int pscOf(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;
  endfunction
  function automatic int expLen(input int p, input logic [1:0] s);
    return (p + 1) * 4 * pscOf(s);
  endfunction
  function automatic int expHi(input int p, input logic [1:0] s, input int d);
    int l;
    l = expLen(p, s);
    if (d == 0) return 0;
    return (d * pscOf(s) < l) ? d * pscOf(s) : l;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int p, input logic [1:0] s, input int d);
    @(negedge clk);
    enable = 1'b0;
    period_wr = 1'b1; period_val = 8'(p);
    duty_wr = 1'b1; {duty_hi, duty_lo} = 10'(d);
    presc_sel = s;
    @(negedge clk);
    period_wr = 1'b0; duty_wr = 1'b0;
  endtask

  // enable and wait for first tick; output must stay low before it (R8)
  task automatic startRun(input int p, input logic [1:0] s);
    int n = 0;
    int highs = 0;
    enable = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (!period_tick && pwm_out) highs++;
    end while (!period_tick && n < 5000);
    chk(highs == 0, "R8 low before first tick", highs, 0);
    chk(n == expLen(p, s), "R8 first tick delay", n, expLen(p, s));
  endtask

  // from a tick cycle, count to the next tick; optional duty write in first clock
  task automatic measure(input bit wr, input int nd, output int len, output int hi);
    int tickLen = 0;
    len = 0; hi = 0;
    if (wr) begin duty_wr = 1'b1; {duty_hi, duty_lo} = 10'(nd); end
    do begin
      if (pwm_out) hi++;
      if (period_tick) tickLen++;
      len++;
      @(negedge clk);
      duty_wr = 1'b0;
    end while (!period_tick && len < 5000);
    chk(tickLen == 1, "R3 tick width", tickLen, 1);
  endtask

  task automatic runCase(input int p, input logic [1:0] s, input int d, input string req);
    int len, hi;
    setup(p, s, d);
    startRun(p, s);
    chk(pwm_out == (d != 0), {req, " wrap level"}, int'(pwm_out), int'(d != 0));
    measure(1'b0, 0, len, hi);
    chk(len == expLen(p, s), "R2 period length", len, expLen(p, s));
    chk(hi == expHi(p, s, d), {req, " high time"}, hi, expHi(p, s, d));
  endtask

  initial begin
    int len, hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pwm_out == 1'b0, "R1 out after reset", int'(pwm_out), 0);
    chk(period_tick == 1'b0, "R1 tick after reset", int'(period_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 default period 0xFF, duty 0 -> stays low
    presc_sel = 2'd0;
    startRun(255, 2'd0);
    measure(1'b0, 0, len, hi);
    chk(len == 1024, "R1 default period", len, 1024);
    chk(hi == 0, "R5 zero duty default", hi, 0);

    // directed corners
    runCase(3, 2'd0, 0, "R5");
    runCase(3, 2'd0, 1, "R4");
    runCase(3, 2'd1, 15, "R4");
    runCase(3, 2'd2, 16, "R6");
    runCase(2, 2'd3, 1023, "R6");
    runCase(63, 2'd0, 200, "R4");

    // R7: duty change during a period applies only from the next one
    setup(4, 2'd1, 6);
    startRun(4, 2'd1);
    measure(1'b1, 13, len, hi);
    chk(hi == expHi(4, 2'd1, 6), "R7 old duty kept", hi, expHi(4, 2'd1, 6));
    measure(1'b0, 0, len, hi);
    chk(hi == expHi(4, 2'd1, 13), "R7 new duty applied", hi, expHi(4, 2'd1, 13));

    // R8: disable while high forces low on next clock
    chk(pwm_out == 1'b1, "R8 high before disable", int'(pwm_out), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R8 low after disable", int'(pwm_out), 0);

    // random cases
    for (int i = 0; i < 14; i++) begin
      int p, d;
      logic [1:0] s;
      p = int'($urandom_range(0, 15));
      s = 2'($urandom_range(0, 3));
      d = int'($urandom_range(0, 4 * (p + 1) + 3));
      runCase(p, s, d, (d == 0) ? "R5" : (d >= 4 * (p + 1)) ? "R6" : "R4");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule